// File: doc/BRIEF.md
# Privileged Handler Trap Entry and Return Controller

This block decides where a 64-bit core goes when it enters or leaves its privileged handler mode. A trap command carries a fault code and the PC of the instruction involved. The block adds a fault-specific vector offset to the handler base register and sends the result to the fetch unit as a redirect, together with the following fetch address. It records a restart address for the handler to return to, and it tracks whether the core is in handler mode. A return command resumes at the recorded restart address. Bit 0 of that address decides whether the core stays in handler mode or goes back to normal mode.

The block also holds the banked integer registers. Eight architectural registers (8 to 14 and 25) each have a normal copy and a shadow copy. The handler-mode flag selects which copy is visible, so entering handler mode from normal mode exposes the shadow copies and leaving handler mode exposes the normal copies again. Every other register index is not stored here. After reset the block issues a first redirect to the reset vector while in handler mode.

Top module: `hmt_trap_unit`

## Requirements
- R1: After reset the block is in handler mode, the restart address is 0, no redirect is pending, and the first redirect is handler base + 0x0001, followed by that address + 4.
- R2: A trap redirects to handler base plus the offset for its fault code: 0 reset 0x0001, 1 machine check 0x0401, 2 arithmetic 0x0501, 3 interrupt 0x0101, 4 data-TLB miss in normal mode 0x0201, 5 data-TLB miss in handler mode 0x0281, 6 alignment 0x0301, 7 data-TLB fault 0x0381, 8 data-TLB access violation 0x0381, 9 instruction-TLB miss 0x0181, 10 instruction-TLB fault 0x0181, 11 instruction-TLB access violation 0x0081, 12 unimplemented opcode 0x0481, 13 FP disabled 0x0581, 14 handler call 0x2001, 15 integer overflow 0x0501.
- R3: Every redirect gives a following fetch address equal to the redirect address + 4.
- R4: A trap with code 2, 14 or 15 records the command PC + 4 as the restart address. Every other code records the command PC itself.
- R5: An interrupt (code 3) taken in handler mode leaves the restart address unchanged. Taken in normal mode, it records the PC.
- R6: A trap from normal mode enters handler mode, which exposes the shadow copies of registers 8-14 and 25. A trap already in handler mode changes neither the mode nor the visible copies. Writes to any other index are ignored, and reading such an index returns 0 with rf_banked low.
- R7: A return command (cmd_is_ret=1) outside handler mode acts as an unimplemented-opcode trap: the redirect goes to base + 0x0481, the PC is recorded, and the block enters handler mode.
- R8: A return command in handler mode redirects to the recorded restart address and does not change that address.
- R9: On a return in handler mode, a restart address with bit 0 clear leaves handler mode and exposes the normal copies again. With bit 0 set, the block stays in handler mode.
- R10: A return in handler mode raises irq_recheck for exactly the cycle after it is accepted. No other command raises it.
- R11: cmd_ready is low while a redirect is pending. A pending redirect keeps its value until redir_ready takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Trap or return command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_is_ret | input | 1 | 1 = return command, 0 = trap |
| cmd_fault | input | 4 | Fault code for a trap (see R2) |
| cmd_pc | input | 64 | PC of the instruction involved |
| hbase | input | 64 | Handler base register |
| redir_valid | output | 1 | Redirect offered to fetch |
| redir_ready | input | 1 | Fetch takes the redirect |
| redir_pc | output | 64 | Redirect target address |
| redir_npc | output | 64 | Following fetch address |
| exc_addr | output | 64 | Recorded restart address |
| hmode | output | 1 | Handler mode flag |
| irq_recheck | output | 1 | One-cycle request to re-evaluate interrupts |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 5 | Register write index |
| rf_wdata | input | 64 | Register write data |
| rf_raddr | input | 5 | Register read index |
| rf_rdata | output | 64 | Visible copy of the read register |
| rf_banked | output | 1 | Read index is one of the banked registers |

## Verification
The bench sends traps from both modes and goes after four corner cases. An interrupt taken inside the handler must not record a new restart address; a design that records it anyway loses the original return point. The skip classes (arithmetic, handler call, integer overflow) must record PC + 4; a design that gets this wrong re-runs or skips the wrong instruction. A return must stay in handler mode when bit 0 of the restart address is set and leave it when bit 0 is clear; a design that ignores bit 0 either drops out of the handler early or never returns to normal mode, and the register readback shows the wrong copy. A return issued outside handler mode must turn into an unimplemented-opcode trap, and the fetch side must see a held redirect under stalls.

// File: rtl/hmt_pkg.sv
package hmt_pkg;

  typedef enum logic [3:0] {
    F_RESET     = 4'd0,
    F_MCHK      = 4'd1,
    F_ARITH     = 4'd2,
    F_INTR      = 4'd3,
    F_DMISS_N   = 4'd4,
    F_DMISS_H   = 4'd5,
    F_ALIGN     = 4'd6,
    F_DFAULT    = 4'd7,
    F_DACV      = 4'd8,
    F_IMISS     = 4'd9,
    F_IFAULT    = 4'd10,
    F_IACV      = 4'd11,
    F_UNIMP     = 4'd12,
    F_FPDIS     = 4'd13,
    F_HCALL     = 4'd14,
    F_IOVF      = 4'd15
  } fault_e;

  localparam int BANK_N = 8;
  localparam int SLOT_W = $clog2(BANK_N);
  localparam int RIDX_W = 5;

  // Vector offset relative to the handler base; bit 0 marks handler-mode PCs.
  function automatic logic [15:0] vec_offset(fault_e f);
    case (f)
      F_RESET:            return 16'h0001;
      F_IACV:             return 16'h0081;
      F_INTR:             return 16'h0101;
      F_IMISS, F_IFAULT:  return 16'h0181;
      F_DMISS_N:          return 16'h0201;
      F_DMISS_H:          return 16'h0281;
      F_ALIGN:            return 16'h0301;
      F_DFAULT, F_DACV:   return 16'h0381;
      F_MCHK:             return 16'h0401;
      F_UNIMP:            return 16'h0481;
      F_ARITH, F_IOVF:    return 16'h0501;
      F_FPDIS:            return 16'h0581;
      F_HCALL:            return 16'h2001;
      default:            return 16'h0001;
    endcase
  endfunction

  // Trap classes that resume after the instruction instead of re-running it.
  function automatic logic skips_insn(fault_e f);
    return (f == F_ARITH) || (f == F_HCALL) || (f == F_IOVF);
  endfunction

  function automatic logic is_banked(logic [RIDX_W-1:0] idx);
    return ((idx >= 5'd8) && (idx <= 5'd14)) || (idx == 5'd25);
  endfunction

  function automatic logic [SLOT_W-1:0] bank_slot(logic [RIDX_W-1:0] idx);
    logic [RIDX_W-1:0] rel;
    rel = idx - 5'd8;
    if (idx == 5'd25) return SLOT_W'(BANK_N - 1);
    return rel[SLOT_W-1:0];
  endfunction

endpackage

// File: rtl/hmt_entry_calc.sv
module hmt_entry_calc
  import hmt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            is_ret,
  input  fault_e          fault,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic            hmode,
  input  logic [XLEN-1:0] exc_cur,
  output logic [XLEN-1:0] tgt_pc,
  output logic [XLEN-1:0] new_exc,
  output logic            exc_we,
  output logic            enter_req,
  output logic            leave_req,
  output logic            ret_ok
);

  fault_e eff_fault;

  always_comb begin
    ret_ok    = is_ret && hmode;
    eff_fault = is_ret ? F_UNIMP : fault;
    tgt_pc    = '0;
    new_exc   = '0;
    exc_we    = 1'b0;
    enter_req = 1'b0;
    leave_req = 1'b0;
    if (ret_ok) begin
      tgt_pc    = exc_cur;
      leave_req = !exc_cur[0];
    end else begin
      tgt_pc    = base + XLEN'(vec_offset(eff_fault));
      exc_we    = !((eff_fault == F_INTR) && hmode);
      new_exc   = skips_insn(eff_fault) ? pc + XLEN'(4) : pc;
      enter_req = !hmode;
    end
  end

endmodule

// File: rtl/hmt_mode_ctl.sv
module hmt_mode_ctl #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            enter_req,
  input  logic            leave_req,
  input  logic            exc_we,
  input  logic [XLEN-1:0] new_exc,
  output logic            hmode,
  output logic [XLEN-1:0] exc_addr,
  output logic            swap_err
);

  logic swap_req;
  assign swap_req = fire && (enter_req || leave_req);
  // A swap toward the bank that is already active.
  assign swap_err = swap_req && ((enter_req && hmode) || (leave_req && !hmode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hmode    <= 1'b1;
      exc_addr <= '0;
    end else begin
      if (swap_req && !swap_err) hmode <= enter_req;
      if (fire && exc_we)        exc_addr <= new_exc;
    end
  end

  assert_mode_flip_needs_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hmode) |-> $past(fire));

  assert_no_redundant_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_err);

  assert_exc_only_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exc_addr) |-> $past(fire && exc_we));

endmodule

// File: rtl/hmt_bank_rf.sv
module hmt_bank_rf
  import hmt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] raddr,
  output logic [XLEN-1:0]   rdata,
  output logic              banked
);

  logic [XLEN-1:0] slot_rd [BANK_N];
  logic            wr_hit;

  assign wr_hit = we && is_banked(waddr);

  for (genvar s = 0; s < BANK_N; s++) begin : g_slot
    logic [XLEN-1:0] live_r;
    logic [XLEN-1:0] shad_r;
    logic            sel_w;
    assign sel_w = wr_hit && (bank_slot(waddr) == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_r <= '0;
        shad_r <= '0;
      end else if (sel_w) begin
        if (bank_sel) shad_r <= wdata;
        else          live_r <= wdata;
      end
    end
    assign slot_rd[s] = bank_sel ? shad_r : live_r;
  end

  assign banked = is_banked(raddr);
  assign rdata  = banked ? slot_rd[bank_slot(raddr)] : '0;

  assert_unbanked_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !banked |-> (rdata == '0));

endmodule

// File: rtl/hmt_trap_unit.sv
module hmt_trap_unit
  import hmt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_ret,
  input  logic [3:0]        cmd_fault,
  input  logic [XLEN-1:0]   cmd_pc,
  input  logic [XLEN-1:0]   hbase,
  output logic              redir_valid,
  input  logic              redir_ready,
  output logic [XLEN-1:0]   redir_pc,
  output logic [XLEN-1:0]   redir_npc,
  output logic [XLEN-1:0]   exc_addr,
  output logic              hmode,
  output logic              irq_recheck,
  input  logic              rf_we,
  input  logic [RIDX_W-1:0] rf_waddr,
  input  logic [XLEN-1:0]   rf_wdata,
  input  logic [RIDX_W-1:0] rf_raddr,
  output logic [XLEN-1:0]   rf_rdata,
  output logic              rf_banked
);

  function automatic logic [XLEN-1:0] next_insn(logic [XLEN-1:0] a);
    return a + XLEN'(4);
  endfunction

  logic            boot_pend;
  logic            fire;
  logic [XLEN-1:0] tgt_pc;
  logic [XLEN-1:0] new_exc;
  logic            exc_we;
  logic            enter_req;
  logic            leave_req;
  logic            ret_ok;
  logic            swap_err;

  assign cmd_ready = !boot_pend && !redir_valid;
  assign fire      = cmd_valid && cmd_ready;

  hmt_entry_calc #(.XLEN(XLEN)) u_calc (
    .is_ret    (cmd_is_ret),
    .fault     (fault_e'(cmd_fault)),
    .pc        (cmd_pc),
    .base      (hbase),
    .hmode     (hmode),
    .exc_cur   (exc_addr),
    .tgt_pc    (tgt_pc),
    .new_exc   (new_exc),
    .exc_we    (exc_we),
    .enter_req (enter_req),
    .leave_req (leave_req),
    .ret_ok    (ret_ok)
  );

  hmt_mode_ctl #(.XLEN(XLEN)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .enter_req (enter_req),
    .leave_req (leave_req),
    .exc_we    (exc_we),
    .new_exc   (new_exc),
    .hmode     (hmode),
    .exc_addr  (exc_addr),
    .swap_err  (swap_err)
  );

  hmt_bank_rf #(.XLEN(XLEN)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (hmode),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .raddr    (rf_raddr),
    .rdata    (rf_rdata),
    .banked   (rf_banked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_pend   <= 1'b1;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
      irq_recheck <= 1'b0;
    end else begin
      irq_recheck <= fire && ret_ok;
      if (redir_valid && redir_ready) redir_valid <= 1'b0;
      if (boot_pend) begin
        boot_pend   <= 1'b0;
        redir_valid <= 1'b1;
        redir_pc    <= hbase + XLEN'(vec_offset(F_RESET));
        redir_npc   <= next_insn(hbase + XLEN'(vec_offset(F_RESET)));
      end else if (fire) begin
        redir_valid <= 1'b1;
        redir_pc    <= tgt_pc;
        redir_npc   <= next_insn(tgt_pc);
      end
    end
  end

  assert_intr_keeps_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd_is_ret && (cmd_fault == 4'd3) && hmode) |=> $stable(exc_addr));

  assert_redir_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_ready) |=> (redir_valid && $stable(redir_pc) && $stable(redir_npc)));

  assert_no_accept_while_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !cmd_ready);

  assert_recheck_after_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_recheck |-> $past(fire && cmd_is_ret && hmode));

  assert_ret_bit0_leaves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_is_ret && hmode && !exc_addr[0]) |=> !hmode);

  assert_ret_keeps_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_is_ret && hmode) |=> $stable(exc_addr));

  assert_npc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_npc == redir_pc + XLEN'(4)));

endmodule

// File: tb/test_hmt_trap_unit.sv
`timescale 1ns/1ps
module test_hmt_trap_unit;

  localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_is_ret = 1'b0;
  logic [3:0]  cmd_fault = 4'd0;
  logic [63:0] cmd_pc = '0;
  logic [63:0] hbase = BASE;
  logic        redir_valid;
  logic        redir_ready = 1'b0;
  logic [63:0] redir_pc;
  logic [63:0] redir_npc;
  logic [63:0] exc_addr;
  logic        hmode;
  logic        irq_recheck;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [63:0] rf_wdata = '0;
  logic [4:0]  rf_raddr = '0;
  logic [63:0] rf_rdata;
  logic        rf_banked;

  int n_checks = 0;
  int n_fail = 0;

  logic [127:0] exp_q[$];
  logic         m_mode;
  logic [63:0]  m_exc;

  always #4 clk = ~clk;

  hmt_trap_unit i_hmt_trap_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_ret(cmd_is_ret), .cmd_fault(cmd_fault), .cmd_pc(cmd_pc), .hbase(hbase),
    .redir_valid(redir_valid), .redir_ready(redir_ready), .redir_pc(redir_pc),
    .redir_npc(redir_npc), .exc_addr(exc_addr), .hmode(hmode), .irq_recheck(irq_recheck),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_banked(rf_banked)
  );

  function automatic logic [63:0] off_of(int code);
    case (code)
      0: return 64'h1;      1: return 64'h401;   2: return 64'h501;   3: return 64'h101;
      4: return 64'h201;    5: return 64'h281;   6: return 64'h301;   7: return 64'h381;
      8: return 64'h381;    9: return 64'h181;   10: return 64'h181;  11: return 64'h81;
      12: return 64'h481;   13: return 64'h581;  14: return 64'h2001; default: return 64'h501;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: computes the expected outcome, pushes the redirect, drives the command.
  task automatic issue(string req, bit is_ret, int code, logic [63:0] pc);
    logic [63:0] tgt;
    bit exp_re;
    int f;
    exp_re = 0;
    if (is_ret && m_mode) begin
      tgt = m_exc;
      if (!m_exc[0]) m_mode = 0;
      exp_re = 1;
    end else begin
      f = is_ret ? 12 : code;
      tgt = BASE + off_of(f);
      if (!(f == 3 && m_mode)) m_exc = (f == 2 || f == 14 || f == 15) ? pc + 64'd4 : pc;
      m_mode = 1;
    end
    exp_q.push_back({tgt, tgt + 64'd4});
    while (!cmd_ready) begin @(posedge clk); #1; end
    cmd_valid = 1'b1; cmd_is_ret = is_ret; cmd_fault = 4'(code); cmd_pc = pc;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    chk({req, " mode"}, 64'(hmode), 64'(m_mode));
    chk({req, " exc"}, exc_addr, m_exc);
    chk({req, " R10 recheck"}, 64'(irq_recheck), 64'(exp_re));
  endtask

  task automatic wr(int idx, logic [63:0] v);
    rf_we = 1'b1; rf_waddr = 5'(idx); rf_wdata = v;
    @(posedge clk); #1;
    rf_we = 1'b0;
  endtask

  task automatic rd(string req, int idx, logic [63:0] v, bit bk);
    rf_raddr = 5'(idx);
    #1;
    chk({req, " rdata"}, rf_rdata, v);
    chk({req, " banked"}, 64'(rf_banked), 64'(bk));
  endtask

  // Fetch-side backpressure pattern.
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      redir_ready = cnt[0] ^ cnt[2];
      cnt++;
    end
  end

  // Monitor: pops expected redirects as fetch takes them; checks holding (R11).
  initial begin
    logic [63:0] held;
    bit was_held = 0;
    forever begin
      @(negedge clk);
      if (rst_n && redir_valid) begin
        if (was_held) chk("R11 held redirect", redir_pc, held);
        if (redir_ready) begin
          if (exp_q.size() == 0) chk("R2 unexpected redirect", redir_pc, 64'hx);
          else begin
            logic [127:0] e;
            e = exp_q.pop_front();
            chk("R2/R8 redirect pc", redir_pc, e[127:64]);
            chk("R3 redirect npc", redir_npc, e[63:0]);
          end
          was_held = 0;
        end else begin
          was_held = 1; held = redir_pc;
        end
      end else was_held = 0;
    end
  end

  initial begin
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    m_mode = 1; m_exc = '0;
    exp_q.push_back({BASE + 64'h1, BASE + 64'h5});
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset mode", 64'(hmode), 64'd1);
    chk("R1 reset exc", exc_addr, 64'd0);
    chk("R1 no redirect in reset", 64'(redir_valid), 64'd0);
    chk("R11 not ready in reset", 64'(cmd_ready), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    wr(8, 64'h5555_0008); wr(25, 64'h5555_0025);
    rd("R6 shadow after reset", 8, 64'h5555_0008, 1);
    issue("R9 return bit0 clear", 1, 0, 64'h0);
    rd("R9 normal copy after leave", 8, 64'h0, 1);
    wr(8, 64'hAAAA_0008); wr(25, 64'hAAAA_0025); wr(3, 64'hDEAD);
    rd("R6 unbanked ignored", 3, 64'h0, 0);
    rd("R6 normal reg 25", 25, 64'hAAAA_0025, 1);
    issue("R4 alignment from normal", 0, 6, 64'h1000);
    rd("R6 shadow reg 8", 8, 64'h5555_0008, 1);
    rd("R6 shadow reg 25", 25, 64'h5555_0025, 1);
    issue("R5 interrupt in handler", 0, 3, 64'h2001);
    rd("R6 no swap in handler", 8, 64'h5555_0008, 1);
    issue("R4 handler call skip", 0, 14, 64'h3001);
    issue("R9 return bit0 set", 1, 0, 64'h0);
    rd("R9 still shadow", 25, 64'h5555_0025, 1);
    issue("R4 data miss", 0, 4, 64'h4000);
    issue("R8 return to exc", 1, 0, 64'h0);
    rd("R9 normal copy back", 8, 64'hAAAA_0008, 1);
    issue("R7 return outside handler", 1, 0, 64'h5000);
    rd("R7 shadow visible", 8, 64'h5555_0008, 1);
    for (int i = 0; i < 16; i++) issue("R2 vector sweep", 0, i, 64'h8000 + 64'(i * 16));
    issue("R4 fault before leaving", 0, 1, 64'h6100);
    issue("R9 leave", 1, 0, 64'h0);
    issue("R5 interrupt from normal", 0, 3, 64'h6000);
    issue("R9 leave again", 1, 0, 64'h0);
    issue("R4 overflow from normal", 0, 15, 64'h7000);
    begin
      int t = 0;
      while ((exp_q.size() != 0 || redir_valid) && t < 1000) begin @(posedge clk); #1; t++; end
    end
    chk("R11 all redirects delivered", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule